// File: doc/BRIEF.md
# Program Flash and Data RAM Access Router

This block sits between a byte-wide CPU and two on-chip memories: the program flash array and a 4096-byte data RAM. It decodes each request by kind (instruction fetch, code-space read, data-space read, data-space write) and steers it to the right array. It checks each request against the flash map and the protected top page. For each accepted request it returns one response beat. The flash size is set by a parameter: either a 64 KB map whose top 1 KB page is reserved, or a 32 KB map with the upper half unpopulated.

Two mode inputs let software turn data-space writes into flash commands. With the write-redirect bit alone, a data write programs one flash byte. With both bits set, the write erases the whole 1 KB page that holds the address. The router hands a command to the flash through a level request and waits for a done pulse. While it waits it holds `busy_o`, and the CPU stalls. A third input maps the bottom 1 KB of flash onto a separate data-only scratchpad. Writes that would touch the page holding the security lock byte, or any reserved address, are refused and set a sticky error flag.

Top module: `flash_xram_router`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid_i`=1 and `busy_o`=0. Kind encoding is 0=fetch, 1=code read, 2=data read, 3=data write. For a fetch or code read at a populated address, the router asserts `fl_rd_o` in the request cycle, and `rsp_valid_o` is 1 in the next cycle with the flash byte on `rsp_data_o`.
- R2: In the 64 KB map, a fetch or code read above the lock byte 0xFBFF (0xFC00–0xFFFF) issues no flash read and responds with `rsp_err_o`=1 and data 0x00. The lock byte 0xFBFF itself reads normally. In the 32 KB map, 0x8000 and above are treated the same way.
- R3: With `scratch_sel_i`=1, flash accesses at 0x0000–0x03FF drive `fl_sp_o`=1 and use the scratchpad. Address 0x0400 and above, or `scratch_sel_i`=0, use main flash with `fl_sp_o`=0.
- R4: A data read goes to the data RAM at address bits [11:0], whatever the redirect bits are. The data arrives one cycle later on `rsp_data_o`.
- R5: A data write with `redir_wr_i`=0 writes the data RAM at bits [11:0]. `redir_erase_i` alone has no effect on where it goes.
- R6: A data write with `redir_wr_i`=1 and `redir_erase_i`=0 leaves the data RAM untouched. The cycle after acceptance, `fl_cmd_o`=1, `fl_erase_o`=0, `fl_addr_o`=request address and `fl_wdata_o`=request data. `busy_o` stays 1 until `fl_done_i`.
- R7: A data write with both redirect bits set issues an erase command with `fl_erase_o`=1 and `fl_addr_o` equal to the address with bits [9:0] cleared.
- R8: A redirected write to the lock page (0xF800–0xFBFF in the 64 KB map, 0x7C00–0x7FFF in the 32 KB map) or to a reserved address issues no command and does not raise busy. The next cycle it gives `rsp_valid_o`=1 with `rsp_err_o`=1 and sets `prot_err_o`, which stays 1 until reset.
- R9: While `busy_o`=1 no request is accepted. In the cycle after `fl_done_i` is sampled, `busy_o`=0 and `rsp_valid_o`=1 with `rsp_err_o`=0. A request held through that cycle is accepted on its closing edge.
- R10: After reset `busy_o`, `rsp_valid_o`, `rsp_err_o` and `prot_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_kind_i | input | 2 | 0 fetch, 1 code read, 2 data read, 3 data write |
| req_addr_i | input | 16 | Request address |
| req_wdata_i | input | 8 | Write data |
| scratch_sel_i | input | 1 | Map low 1 KB of flash to the scratchpad |
| redir_wr_i | input | 1 | Redirect data writes to flash program |
| redir_erase_i | input | 1 | With redir_wr_i, redirect data writes to page erase |
| busy_o | output | 1 | Flash command in progress; requests stall |
| rsp_valid_o | output | 1 | Response beat |
| rsp_data_o | output | 8 | Read data |
| rsp_err_o | output | 1 | Response refers to a refused or reserved access |
| prot_err_o | output | 1 | Sticky protection violation flag |
| fl_rd_o | output | 1 | Flash read strobe |
| fl_sp_o | output | 1 | Flash access targets the scratchpad |
| fl_addr_o | output | 16 | Flash address (read or command) |
| fl_rdata_i | input | 8 | Flash read data, one cycle after fl_rd_o |
| fl_cmd_o | output | 1 | Flash command request, held until done |
| fl_erase_o | output | 1 | Command is a page erase |
| fl_wdata_o | output | 8 | Program data |
| fl_done_i | input | 1 | Command completion pulse |
| xr_rd_o | output | 1 | Data RAM read strobe |
| xr_wr_o | output | 1 | Data RAM write strobe |
| xr_addr_o | output | 12 | Data RAM address |
| xr_wdata_o | output | 8 | Data RAM write data |
| xr_rdata_i | input | 8 | Data RAM read data, one cycle after xr_rd_o |

## Verification
The completion response of a flash command and the acceptance of the next request can happen in the same cycle. The cycle after the done pulse both ends the stall and must take a request that the CPU has held valid throughout. The bench starts a program command and then holds a data read valid during the whole busy window. Before done, no response may appear and the read must not be accepted. The completion beat must then come with busy low, and the RAM data must follow one cycle later. A second case issues a data read with redirection on: it must still go to the RAM while the same mode bits turn a write into a flash command.

// File: rtl/fxr_pkg.sv
package fxr_pkg;
  typedef enum logic [1:0] {
    REQ_FETCH   = 2'd0,
    REQ_CODE_RD = 2'd1,
    REQ_DATA_RD = 2'd2,
    REQ_DATA_WR = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_FLASH = 2'd1,
    SRC_XRAM  = 2'd2
  } rsp_src_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic flash_rd;
    logic xram_rd;
    logic xram_wr;
    logic flash_cmd;
    logic erase;
    logic scratch;
    logic reserved;
    logic blocked;
  } route_t;
endpackage

// File: rtl/fxr_addr_class.sv
module fxr_addr_class #(
  parameter int AW          = 16,
  parameter int PAGE_AW     = 10,
  parameter int SCRATCH_AW  = 10,
  parameter bit LARGE_FLASH = 1'b1
) (
  input  logic [AW-1:0] addr_i,
  input  logic          scratch_sel_i,
  output logic          scratch_o,
  output logic          reserved_o,
  output logic          lock_page_o
);
  localparam int PG_W      = AW - PAGE_AW;
  localparam int LOCK_PG_I = LARGE_FLASH ? (2**PG_W) - 2 : (2**(PG_W-1)) - 1;
  localparam logic [PG_W-1:0] LOCK_PG = LOCK_PG_I[PG_W-1:0];

  assign scratch_o   = scratch_sel_i && (addr_i[AW-1:SCRATCH_AW] == '0);
  assign lock_page_o = (addr_i[AW-1:PAGE_AW] == LOCK_PG);

  generate
    if (LARGE_FLASH) begin : g_large
      // top page above the lock byte is reserved
      assign reserved_o = &addr_i[AW-1:PAGE_AW];
    end else begin : g_small
      // upper half unpopulated
      assign reserved_o = addr_i[AW-1];
    end
  endgenerate
endmodule

// File: rtl/fxr_route.sv
module fxr_route
  import fxr_pkg::*;
(
  input  logic      accept_i,
  input  logic [1:0] kind_i,
  input  logic      scratch_i,
  input  logic      reserved_i,
  input  logic      lock_page_i,
  input  logic      redir_wr_i,
  input  logic      redir_erase_i,
  output route_t    route_o
);
  always_comb begin
    route_o = '0;
    route_o.scratch = scratch_i;
    if (accept_i) begin
      unique case (req_kind_e'(kind_i))
        REQ_FETCH, REQ_CODE_RD: begin
          if (!scratch_i && reserved_i) route_o.reserved = 1'b1;
          else                          route_o.flash_rd = 1'b1;
        end
        REQ_DATA_RD: route_o.xram_rd = 1'b1;
        REQ_DATA_WR: begin
          if (!redir_wr_i) begin
            route_o.xram_wr = 1'b1;
          end else if (!scratch_i && (reserved_i || lock_page_i)) begin
            route_o.blocked = 1'b1;
          end else begin
            route_o.flash_cmd = 1'b1;
            route_o.erase     = redir_erase_i;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fxr_cmd_seq.sv
module fxr_cmd_seq
  import fxr_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int PAGE_AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          erase_i,
  input  logic          sp_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          done_i,
  output logic          busy_o,
  output logic          finish_o,
  output logic          cmd_erase_o,
  output logic          cmd_sp_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_wdata_o
);
  localparam logic [AW-1:0] PG_MASK = ~AW'((2**PAGE_AW) - 1);

  seq_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SEQ_IDLE;
      cmd_erase_o <= 1'b0;
      cmd_sp_o    <= 1'b0;
      cmd_addr_o  <= '0;
      cmd_wdata_o <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q     <= SEQ_BUSY;
          cmd_erase_o <= erase_i;
          cmd_sp_o    <= sp_i;
          cmd_addr_o  <= erase_i ? (addr_i & PG_MASK) : addr_i;
          cmd_wdata_o <= wdata_i;
        end
        SEQ_BUSY: if (done_i) state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q == SEQ_BUSY);
  assign finish_o = busy_o && done_i;
endmodule

// File: rtl/flash_xram_router.sv
module flash_xram_router
  import fxr_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int XRAM_AW     = 12,
  parameter int PAGE_AW     = 10,
  parameter int SCRATCH_AW  = 10,
  parameter bit LARGE_FLASH = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         req_kind_i,
  input  logic [AW-1:0]      req_addr_i,
  input  logic [DW-1:0]      req_wdata_i,
  input  logic               scratch_sel_i,
  input  logic               redir_wr_i,
  input  logic               redir_erase_i,
  output logic               busy_o,
  output logic               rsp_valid_o,
  output logic [DW-1:0]      rsp_data_o,
  output logic               rsp_err_o,
  output logic               prot_err_o,
  output logic               fl_rd_o,
  output logic               fl_sp_o,
  output logic [AW-1:0]      fl_addr_o,
  input  logic [DW-1:0]      fl_rdata_i,
  output logic               fl_cmd_o,
  output logic               fl_erase_o,
  output logic [DW-1:0]      fl_wdata_o,
  input  logic               fl_done_i,
  output logic               xr_rd_o,
  output logic               xr_wr_o,
  output logic [XRAM_AW-1:0] xr_addr_o,
  output logic [DW-1:0]      xr_wdata_o,
  input  logic [DW-1:0]      xr_rdata_i
);
  logic       scratch, reserved, lock_page, accept, finish;
  logic       cmd_sp;
  logic [AW-1:0] cmd_addr;
  route_t     route;
  rsp_src_e   src_q;
  logic       rsp_valid_q, rsp_err_q, prot_err_q;

  assign accept = req_valid_i && !busy_o;

  fxr_addr_class #(
    .AW(AW), .PAGE_AW(PAGE_AW), .SCRATCH_AW(SCRATCH_AW), .LARGE_FLASH(LARGE_FLASH)
  ) u_class (
    .addr_i       (req_addr_i),
    .scratch_sel_i(scratch_sel_i),
    .scratch_o    (scratch),
    .reserved_o   (reserved),
    .lock_page_o  (lock_page)
  );

  fxr_route u_route (
    .accept_i     (accept),
    .kind_i       (req_kind_i),
    .scratch_i    (scratch),
    .reserved_i   (reserved),
    .lock_page_i  (lock_page),
    .redir_wr_i   (redir_wr_i),
    .redir_erase_i(redir_erase_i),
    .route_o      (route)
  );

  fxr_cmd_seq #(.AW(AW), .DW(DW), .PAGE_AW(PAGE_AW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (route.flash_cmd),
    .erase_i    (route.erase),
    .sp_i       (route.scratch),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .done_i     (fl_done_i),
    .busy_o     (busy_o),
    .finish_o   (finish),
    .cmd_erase_o(fl_erase_o),
    .cmd_sp_o   (cmd_sp),
    .cmd_addr_o (cmd_addr),
    .cmd_wdata_o(fl_wdata_o)
  );

  // response tracking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      prot_err_q  <= 1'b0;
      src_q       <= SRC_NONE;
    end else begin
      rsp_valid_q <= (accept && !route.flash_cmd) || finish;
      rsp_err_q   <= route.reserved || route.blocked;
      if (route.blocked) prot_err_q <= 1'b1;
      if (route.flash_rd)     src_q <= SRC_FLASH;
      else if (route.xram_rd) src_q <= SRC_XRAM;
      else                    src_q <= SRC_NONE;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_FLASH: rsp_data_o = fl_rdata_i;
      SRC_XRAM:  rsp_data_o = xr_rdata_i;
      default:   rsp_data_o = '0;
    endcase
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign prot_err_o  = prot_err_q;

  assign fl_rd_o   = route.flash_rd;
  assign fl_cmd_o  = busy_o;
  assign fl_addr_o = busy_o ? cmd_addr : req_addr_i;
  assign fl_sp_o   = busy_o ? cmd_sp : (route.flash_rd && route.scratch);

  assign xr_rd_o    = route.xram_rd;
  assign xr_wr_o    = route.xram_wr;
  assign xr_addr_o  = req_addr_i[XRAM_AW-1:0];
  assign xr_wdata_o = req_wdata_i;
endmodule

// File: rtl/fxr_checker.sv
module fxr_checker #(
  parameter int AW      = 16,
  parameter int PAGE_AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          fl_cmd_o,
  input logic          fl_erase_o,
  input logic [AW-1:0] fl_addr_o,
  input logic          fl_done_i,
  input logic          fl_rd_o,
  input logic          xr_rd_o,
  input logic          xr_wr_o,
  input logic          rsp_valid_o,
  input logic          prot_err_o
);
  AST_CMD_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_cmd_o |-> busy_o); // R6
  AST_CMD_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_cmd_o && !fl_done_i) |=> (!fl_cmd_o || $stable(fl_addr_o))); // R6
  AST_ERASE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_cmd_o && fl_erase_o) |-> (fl_addr_o[PAGE_AW-1:0] == '0)); // R7
  AST_PROT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_err_o |=> prot_err_o); // R8
  AST_PROT_NO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prot_err_o) |-> !fl_cmd_o); // R8
  AST_STALL_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(fl_rd_o || xr_rd_o || xr_wr_o)); // R9
  AST_DONE_RESPONDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && fl_done_i) |=> (rsp_valid_o && !busy_o)); // R9
  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fl_rd_o, xr_rd_o, xr_wr_o})); // R4
endmodule

bind flash_xram_router fxr_checker #(.AW(AW), .PAGE_AW(PAGE_AW)) u_fxr_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .fl_cmd_o   (fl_cmd_o),
  .fl_erase_o (fl_erase_o),
  .fl_addr_o  (fl_addr_o),
  .fl_done_i  (fl_done_i),
  .fl_rd_o    (fl_rd_o),
  .xr_rd_o    (xr_rd_o),
  .xr_wr_o    (xr_wr_o),
  .rsp_valid_o(rsp_valid_o),
  .prot_err_o (prot_err_o)
);

// File: tb/tb_flash_xram_router.sv
module tb_flash_xram_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        scratch_sel = 1'b0, redir_wr = 1'b0, redir_erase = 1'b0;
  logic        busy, rsp_valid, rsp_err, prot_err;
  logic [7:0]  rsp_data;
  logic        fl_rd, fl_sp, fl_cmd, fl_erase;
  logic [15:0] fl_addr;
  logic [7:0]  fl_wdata;
  logic [7:0]  fl_rdata = '0;
  logic        fl_done = 1'b0;
  logic        xr_rd, xr_wr;
  logic [11:0] xr_addr;
  logic [7:0]  xr_wdata;
  logic [7:0]  xr_rdata = '0;

  int checks = 0;
  int failures = 0;

  logic [7:0] fmem [int];
  logic [7:0] smem [int];
  logic [7:0] xmem [4096];
  logic       pend = 1'b0;
  int         dcnt = 0;

  always #4 clk = ~clk;

  flash_xram_router dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_kind_i(req_kind), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .scratch_sel_i(scratch_sel), .redir_wr_i(redir_wr),
    .redir_erase_i(redir_erase), .busy_o(busy), .rsp_valid_o(rsp_valid),
    .rsp_data_o(rsp_data), .rsp_err_o(rsp_err), .prot_err_o(prot_err),
    .fl_rd_o(fl_rd), .fl_sp_o(fl_sp), .fl_addr_o(fl_addr), .fl_rdata_i(fl_rdata),
    .fl_cmd_o(fl_cmd), .fl_erase_o(fl_erase), .fl_wdata_o(fl_wdata), .fl_done_i(fl_done),
    .xr_rd_o(xr_rd), .xr_wr_o(xr_wr), .xr_addr_o(xr_addr), .xr_wdata_o(xr_wdata),
    .xr_rdata_i(xr_rdata)
  );

  // behavioural flash: sync read, command done three cycles after start
  always @(posedge clk) begin
    if (fl_rd) begin
      if (fl_sp) fl_rdata <= smem.exists(int'(fl_addr)) ? smem[int'(fl_addr)] : 8'hFF;
      else       fl_rdata <= fmem.exists(int'(fl_addr)) ? fmem[int'(fl_addr)] : 8'hFF;
    end
    fl_done <= 1'b0;
    if (!pend && fl_cmd && !fl_done) begin
      pend <= 1'b1;
      dcnt <= 0;
      if (fl_erase) begin
        for (int i = 0; i < 1024; i++) begin
          if (fl_sp) smem.delete(i);
          else       fmem.delete(int'(fl_addr) + i);
        end
      end else if (fl_sp) begin
        smem[int'(fl_addr)] = (smem.exists(int'(fl_addr)) ? smem[int'(fl_addr)] : 8'hFF) & fl_wdata;
      end else begin
        fmem[int'(fl_addr)] = (fmem.exists(int'(fl_addr)) ? fmem[int'(fl_addr)] : 8'hFF) & fl_wdata;
      end
    end else if (pend) begin
      if (dcnt == 2) begin
        fl_done <= 1'b1;
        pend    <= 1'b0;
      end else dcnt <= dcnt + 1;
    end
  end

  always @(posedge clk) begin
    if (xr_wr) xmem[xr_addr] <= xr_wdata;
    if (xr_rd) xr_rdata <= xmem[xr_addr];
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, return at next negedge with the response visible
  task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [1:0] k, input logic [15:0] a,
                          input int exp_data, input int exp_err);
    issue(k, a, 8'h00);
    chk(req, "rsp_valid", int'(rsp_valid), 1);
    chk(req, "rsp_err", int'(rsp_err), exp_err);
    chk(req, "rsp_data", int'(rsp_data), exp_data);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!rsp_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(req, "cmd completion", int'(rsp_valid && !busy), 1);
  endtask

  task automatic t_reset;
    chk("R10", "busy", int'(busy), 0);
    chk("R10", "rsp_valid", int'(rsp_valid), 0);
    chk("R10", "rsp_err", int'(rsp_err), 0);
    chk("R10", "prot_err", int'(prot_err), 0);
  endtask

  task automatic t_code_reads;
    fmem[16'h1234] = 8'h5A;
    fmem[16'h0100] = 8'h11;
    read_chk("R1", 2'd0, 16'h1234, 8'h5A, 0);
    read_chk("R1", 2'd1, 16'h0100, 8'h11, 0);
  endtask

  task automatic t_reserved;
    fmem[16'hFBFF] = 8'hA5;
    req_valid = 1'b1; req_kind = 2'd1; req_addr = 16'hFC00; #1;
    chk("R2", "no flash read on reserved", int'(fl_rd), 0);
    @(negedge clk); req_valid = 1'b0;
    chk("R2", "reserved err", int'(rsp_err), 1);
    chk("R2", "reserved data", int'(rsp_data), 0);
    read_chk("R2", 2'd0, 16'hFFFF, 8'h00, 1);
    read_chk("R2", 2'd1, 16'hFBFF, 8'hA5, 0);
  endtask

  task automatic t_scratch;
    smem[16'h0010] = 8'h77;
    fmem[16'h0010] = 8'h33;
    fmem[16'h0400] = 8'h44;
    scratch_sel = 1'b1;
    req_valid = 1'b1; req_kind = 2'd1; req_addr = 16'h0010; #1;
    chk("R3", "fl_sp in window", int'(fl_sp), 1);
    @(negedge clk); req_valid = 1'b0;
    chk("R3", "scratch data", int'(rsp_data), 8'h77);
    read_chk("R3", 2'd1, 16'h0400, 8'h44, 0);
    scratch_sel = 1'b0;
    read_chk("R3", 2'd1, 16'h0010, 8'h33, 0);
  endtask

  task automatic t_xram;
    issue(2'd3, 16'h0123, 8'h9C);
    chk("R5", "xram write rsp", int'(rsp_valid && !rsp_err), 1);
    redir_wr = 1'b1;
    read_chk("R4", 2'd2, 16'h0123, 8'h9C, 0);
    read_chk("R4", 2'd2, 16'h1123, 8'h9C, 0);
    redir_wr = 1'b0;
    redir_erase = 1'b1;
    issue(2'd3, 16'h0200, 8'h3C);
    chk("R5", "erase-only busy", int'(busy), 0);
    read_chk("R5", 2'd2, 16'h0200, 8'h3C, 0);
    read_chk("R5", 2'd1, 16'h0200, 8'hFF, 0);
    redir_erase = 1'b0;
  endtask

  task automatic t_program;
    issue(2'd3, 16'h0000, 8'h21);
    redir_wr = 1'b1;
    issue(2'd3, 16'h2000, 8'h0F);
    chk("R6", "busy", int'(busy), 1);
    chk("R6", "fl_cmd", int'(fl_cmd), 1);
    chk("R6", "fl_erase", int'(fl_erase), 0);
    chk("R6", "fl_addr", int'(fl_addr), 16'h2000);
    chk("R6", "fl_wdata", int'(fl_wdata), 8'h0F);
    wait_done("R6");
    read_chk("R6", 2'd1, 16'h2000, 8'h0F, 0);
    read_chk("R6", 2'd2, 16'h0000, 8'h21, 0);
    redir_wr = 1'b0;
  endtask

  task automatic t_erase;
    fmem[16'h2005] = 8'h12;
    redir_wr = 1'b1; redir_erase = 1'b1;
    issue(2'd3, 16'h2005, 8'h00);
    chk("R7", "fl_erase", int'(fl_erase), 1);
    chk("R7", "page base addr", int'(fl_addr), 16'h2000);
    wait_done("R7");
    redir_wr = 1'b0; redir_erase = 1'b0;
    read_chk("R7", 2'd1, 16'h2005, 8'hFF, 0);
    read_chk("R7", 2'd1, 16'h2000, 8'hFF, 0);
  endtask

  task automatic t_protect;
    fmem[16'hF900] = 8'h66;
    redir_wr = 1'b1;
    issue(2'd3, 16'hF900, 8'h00);
    chk("R8", "rsp_err lock page", int'(rsp_valid && rsp_err), 1);
    chk("R8", "no busy", int'(busy), 0);
    chk("R8", "prot_err set", int'(prot_err), 1);
    issue(2'd3, 16'hFE00, 8'h00);
    chk("R8", "reserved write err", int'(rsp_err && !busy), 1);
    redir_wr = 1'b0;
    read_chk("R8", 2'd1, 16'hF900, 8'h66, 0);
    chk("R8", "prot_err sticky", int'(prot_err), 1);
  endtask

  task automatic t_stall;
    int n = 0;
    bit early = 0;
    xmem[12'h055] = 8'hB4;
    redir_wr = 1'b1;
    issue(2'd3, 16'h3000, 8'hF0);
    req_valid = 1'b1; req_kind = 2'd2; req_addr = 16'h0055;
    while (busy && n < 40) begin
      if (rsp_valid || xr_rd) early = 1;
      @(negedge clk);
      n++;
    end
    chk("R9", "no accept while busy", int'(early), 0);
    chk("R9", "completion beat", int'(rsp_valid && !rsp_err && !busy), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "held read valid", int'(rsp_valid), 1);
    chk("R9", "held read data", int'(rsp_data), 8'hB4);
    redir_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_code_reads();
    t_reserved();
    t_scratch();
    t_xram();
    t_program();
    t_erase();
    t_stall();
    t_protect();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule